// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table stored in memory. The address splits into three fields. The top ten bits index a first-level table whose start address the requester supplies with each request. The next ten bits index the second-level table that the first-level entry points to. The low twelve bits are the byte offset inside a 4 KB page.

The walker makes one memory read for each level. The reads go out in sequence through a single read port that uses a request/ready handshake and accepts responses after any delay. A successful walk therefore costs two reads before the data access itself can start. Each table entry is a 32-bit word: bits 31:12 hold a table start or a frame number, and bit 0 is a valid flag. If either entry is not valid, the walk stops at once and reports a fault that names the failing level.

The result appears as a one-cycle pulse, and the walker then accepts the next request. There is no translation caching in this block.

Top module: `pt2_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_rd_valid` is 0 and `res_valid` is 0.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` both 1 at a clock edge), `mem_rd_valid` is 1 and `mem_rd_addr` equals `root_base + vaddr[31:22]*4`.
- R3: When the first-level response has bit 0 set, the next read address is `{resp[31:12], 12'b0} + vaddr[21:12]*4`. Response bits 11:1 do not affect this address.
- R4: When the second-level response has bit 0 set, the result has `res_fault` = 0 and `res_paddr` = `{resp[31:12], vaddr[11:0]}`. Response bits 11:1 do not affect the result.
- R5: When the first-level response has bit 0 clear, the result has `res_fault` = 1 and `res_fault_lvl` = 0, and no second read is issued.
- R6: When the second-level response has bit 0 clear, the result has `res_fault` = 1 and `res_fault_lvl` = 1.
- R7: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the request stays valid and `mem_rd_addr` does not change.
- R8: `res_valid` is a pulse of exactly one cycle, in the cycle after the response that ends the walk. `req_ready` is 1 only when no walk is in progress, and a `req_valid` raised during a walk does not change that walk's result.
- R9: A `mem_rsp_valid` that arrives while a read request is still waiting for `mem_rd_ready` is ignored.
- R10: A read response may arrive any number of cycles after its request is accepted, including the very next cycle, and the walk gives the same result for every delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle; request accepted when both are high |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Start address of the first-level table, sampled with the request |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry word |
| res_valid | output | 1 | One-cycle result strobe |
| res_paddr | output | 32 | Translated physical address (zero on fault) |
| res_fault | output | 1 | Walk ended on an invalid entry |
| res_fault_lvl | output | 1 | Failing level: 0 first, 1 second |

## Verification
The bench builds the walker with its default split of 10, 10 and 12 bits, 4-byte entries and the valid flag in bit 0. It models memory arithmetically, so every table word is a closed-form function of its address. It sweeps all 1024 first-level indices and, under one fixed first-level entry, all 1024 second-level indices. Across these walks it changes the response delay, the delay before the read is accepted, and where requests and responses are injected at the wrong moment. This reaches both fault levels, the unused entry bits, held read requests and every table row.

// File: rtl/pt2_pkg.sv
package pt2_pkg;

   typedef enum logic [2:0] {
      W_IDLE,
      W_L1_REQ,
      W_L1_WAIT,
      W_L2_REQ,
      W_L2_WAIT,
      W_DONE
   } walk_state_t;

   localparam logic LVL_FIRST  = 1'b0;
   localparam logic LVL_SECOND = 1'b1;

endpackage

// File: rtl/pt2_va_split.sv
module pt2_va_split #(
   parameter int VA_W  = 32,
   parameter int IDX_W = 10,
   parameter int OFF_W = 12
) (
   input  logic [VA_W-1:0]  vaddr,
   output logic [IDX_W-1:0] hi_idx,
   output logic [IDX_W-1:0] lo_idx,
   output logic [OFF_W-1:0] offset
);
   localparam int LO_BASE = OFF_W;
   localparam int HI_BASE = OFF_W + IDX_W;

   generate
      if (VA_W != 2 * IDX_W + OFF_W) begin : g_bad_split
         $error("pt2_va_split: VA_W must equal 2*IDX_W+OFF_W");
      end
   endgenerate

   assign offset = vaddr[OFF_W-1:0];
   assign lo_idx = vaddr[LO_BASE +: IDX_W];
   assign hi_idx = vaddr[HI_BASE +: IDX_W];
endmodule

// File: rtl/pt2_entry_addr.sv
module pt2_entry_addr #(
   parameter int PA_W        = 32,
   parameter int IDX_W       = 10,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [PA_W-1:0]  tbl_base,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  ent_addr
);
   localparam int SHIFT = $clog2(ENTRY_BYTES);
   logic [PA_W-1:0] byte_off;

   generate
      if (ENTRY_BYTES < 1) begin : g_bad_size
         $error("pt2_entry_addr: ENTRY_BYTES must be positive");
      end
      if ((1 << SHIFT) == ENTRY_BYTES) begin : g_shift
         assign byte_off = PA_W'(idx) << SHIFT;
      end else begin : g_mult
         assign byte_off = PA_W'(idx) * PA_W'(ENTRY_BYTES);
      end
   endgenerate

   assign ent_addr = tbl_base + byte_off;
endmodule

// File: rtl/pt2_entry_decode.sv
module pt2_entry_decode #(
   parameter int PA_W      = 32,
   parameter int OFF_W     = 12,
   parameter int VALID_BIT = 0
) (
   input  logic [PA_W-1:0] ent_word,
   output logic            ent_valid,
   output logic [PA_W-1:0] ent_base
);
   localparam logic [PA_W-1:0] LOW_MASK = PA_W'((64'd1 << OFF_W) - 64'd1);

   generate
      if (VALID_BIT >= OFF_W) begin : g_bad_valid
         $error("pt2_entry_decode: valid flag must sit below the page field");
      end
      if (PA_W <= OFF_W) begin : g_bad_width
         $error("pt2_entry_decode: PA_W must exceed OFF_W");
      end
   endgenerate

   assign ent_valid = ent_word[VALID_BIT];
   assign ent_base  = ent_word & ~LOW_MASK;
endmodule

// File: rtl/pt2_walker.sv
module pt2_walker
   import pt2_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int IDX_W       = 10,
   parameter int OFF_W       = 12,
   parameter int ENTRY_BYTES = 4,
   parameter int VALID_BIT   = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic [PA_W-1:0] root_base,
   output logic            mem_rd_valid,
   input  logic            mem_rd_ready,
   output logic [PA_W-1:0] mem_rd_addr,
   input  logic            mem_rsp_valid,
   input  logic [PA_W-1:0] mem_rsp_data,
   output logic            res_valid,
   output logic [PA_W-1:0] res_paddr,
   output logic            res_fault,
   output logic            res_fault_lvl
);
   localparam int FRAME_W = PA_W - OFF_W;

   walk_state_t      state;
   logic [VA_W-1:0]  va_q;
   logic [PA_W-1:0]  base_q;
   logic [IDX_W-1:0] hi_idx, lo_idx, sel_idx;
   logic [OFF_W-1:0] pg_off;
   logic             ent_valid;
   logic [PA_W-1:0]  ent_base;

   pt2_va_split #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
      .vaddr  (va_q),
      .hi_idx (hi_idx),
      .lo_idx (lo_idx),
      .offset (pg_off)
   );

   assign sel_idx = (state == W_L2_REQ) ? lo_idx : hi_idx;

   pt2_entry_addr #(.PA_W(PA_W), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)) u_addr (
      .tbl_base (base_q),
      .idx      (sel_idx),
      .ent_addr (mem_rd_addr)
   );

   pt2_entry_decode #(.PA_W(PA_W), .OFF_W(OFF_W), .VALID_BIT(VALID_BIT)) u_dec (
      .ent_word  (mem_rsp_data),
      .ent_valid (ent_valid),
      .ent_base  (ent_base)
   );

   assign req_ready    = (state == W_IDLE);
   assign mem_rd_valid = (state == W_L1_REQ) || (state == W_L2_REQ);
   assign res_valid    = (state == W_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= W_IDLE;
         va_q          <= '0;
         base_q        <= '0;
         res_paddr     <= '0;
         res_fault     <= 1'b0;
         res_fault_lvl <= LVL_FIRST;
      end else begin
         case (state)
            W_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr;
                  base_q <= root_base;
                  state  <= W_L1_REQ;
               end
            end
            W_L1_REQ: begin
               if (mem_rd_ready) state <= W_L1_WAIT;
            end
            W_L1_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!ent_valid) begin
                     res_fault     <= 1'b1;
                     res_fault_lvl <= LVL_FIRST;
                     res_paddr     <= '0;
                     state         <= W_DONE;
                  end else begin
                     base_q <= ent_base;
                     state  <= W_L2_REQ;
                  end
               end
            end
            W_L2_REQ: begin
               if (mem_rd_ready) state <= W_L2_WAIT;
            end
            W_L2_WAIT: begin
               if (mem_rsp_valid) begin
                  res_fault_lvl <= LVL_SECOND;
                  if (!ent_valid) begin
                     res_fault <= 1'b1;
                     res_paddr <= '0;
                  end else begin
                     res_fault <= 1'b0;
                     res_paddr <= {ent_base[PA_W-1 -: FRAME_W], pg_off};
                  end
                  state <= W_DONE;
               end
            end
            W_DONE:  state <= W_IDLE;
            default: state <= W_IDLE;
         endcase
      end
   end

   // R2: an accepted request leads straight to a read request
   assert_accept_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> mem_rd_valid);

   // R7: a stalled read request keeps its address
   assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

   // R8: result strobe lasts one cycle
   assert_res_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R8: the result follows a memory response by one cycle
   assert_res_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(mem_rsp_valid));

   // R8: an idle walker issues no read
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_rd_valid);
endmodule

// File: tb/pt2_walker_bench.sv
`timescale 1ns/1ps
module pt2_walker_bench;
   localparam logic [31:0] ROOT = 32'h0001_0000;
   localparam logic [31:0] TBL0 = 32'h0040_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [31:0] root_base = '0;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        res_valid;
   logic [31:0] res_paddr;
   logic        res_fault;
   logic        res_fault_lvl;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pt2_walker u_pt2_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .root_base(root_base), .mem_rd_valid(mem_rd_valid),
      .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .res_valid(res_valid), .res_paddr(res_paddr), .res_fault(res_fault),
      .res_fault_lvl(res_fault_lvl)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit first_ok(int o);
      return (o % 5) != 4;
   endfunction

   function automatic bit second_ok(int o, int i);
      return ((o + i) % 7) != 6;
   endfunction

   function automatic logic [19:0] frame_of(int o, int i);
      return 20'((o * 1024 + i) ^ 32'h5A5A5);
   endfunction

   function automatic logic [31:0] first_word(int o);
      logic [31:0] w;
      w = TBL0 + 32'(o) * 32'd4096;
      w[11:1] = 11'h2AA;
      w[0] = first_ok(o);
      return w;
   endfunction

   function automatic logic [31:0] second_word(int o, int i);
      return {frame_of(o, i), 11'h555, second_ok(o, i)};
   endfunction

   task automatic walk(input int o, input int i, input int off, input int lat,
                       input int rdy_dly, input bit poke, input bit stray);
      logic [31:0] va;
      logic [31:0] exp_a;
      va = {10'(o), 10'(i), 12'(off)};
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; root_base = ROOT;
      @(negedge clk);
      req_valid = 1'b0; req_vaddr = ~va;
      if (stray) begin mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0; end
      exp_a = ROOT + 32'(o) * 4;
      chk(mem_rd_valid === 1'b1 && mem_rd_addr === exp_a, "R2 first read address", mem_rd_addr, exp_a);
      for (int k = 0; k < rdy_dly; k++) begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         chk(mem_rd_valid === 1'b1 && mem_rd_addr === exp_a, "R7 held request", mem_rd_addr, exp_a);
      end
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0;
      if (poke) begin
         req_valid = 1'b1;
         chk(req_ready === 1'b0, "R8 busy not ready", {31'b0, req_ready}, 32'h0);
      end
      for (int k = 0; k < lat; k++) begin @(negedge clk); req_valid = 1'b0; end
      mem_rsp_valid = 1'b1; mem_rsp_data = first_word(o);
      @(negedge clk);
      mem_rsp_valid = 1'b0; req_valid = 1'b0;
      if (!first_ok(o)) begin
         chk(res_valid === 1'b1 && res_fault === 1'b1 && res_fault_lvl === 1'b0 && mem_rd_valid === 1'b0,
             "R5 first-level fault", {res_valid, res_fault, res_fault_lvl, mem_rd_valid}, 4'b1100);
      end else begin
         exp_a = TBL0 + 32'(o) * 4096 + 32'(i) * 4;
         chk(mem_rd_valid === 1'b1 && mem_rd_addr === exp_a, "R3 second read address", mem_rd_addr, exp_a);
         mem_rd_ready = 1'b1;
         @(negedge clk);
         mem_rd_ready = 1'b0;
         for (int k = 0; k < lat; k++) @(negedge clk);
         mem_rsp_valid = 1'b1; mem_rsp_data = second_word(o, i);
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (second_ok(o, i)) begin
            exp_a = {frame_of(o, i), 12'(off)};
            chk(res_valid === 1'b1 && res_fault === 1'b0 && res_paddr === exp_a,
                (lat > 1) ? "R4 R10 translated address" : "R4 translated address", res_paddr, exp_a);
            if (stray) chk(res_fault === 1'b0, "R9 stray response ignored", {31'b0, res_fault}, 32'h0);
            if (poke) chk(res_paddr === exp_a, "R8 busy request ignored", res_paddr, exp_a);
         end else begin
            chk(res_valid === 1'b1 && res_fault === 1'b1 && res_fault_lvl === 1'b1,
                "R6 second-level fault", {res_valid, res_fault, res_fault_lvl}, 3'b111);
         end
      end
      @(negedge clk);
      chk(res_valid === 1'b0 && req_ready === 1'b1, "R8 single pulse then idle",
          {res_valid, req_ready}, 2'b01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && mem_rd_valid === 1'b0 && res_valid === 1'b0, "R1 reset state",
          {req_ready, mem_rd_valid, res_valid}, 3'b100);
      for (int o = 0; o < 1024; o++)
         walk(o, (o * 37) % 1024, (o * 13) % 4096, o % 4, (o / 4) % 3, (o % 8) == 5, (o % 16) == 3);
      for (int i = 0; i < 1024; i++)
         walk(3, i, (i * 5) % 4096, (i % 2) * 3, i % 2, 1'b0, 1'b0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule